// File: doc/BRIEF.md
# Receive Sample Format Packer

This block takes one receive channel's signed 16-bit I/Q samples, each announced by a single-cycle valid strobe, and turns them into a stream of 16-bit host words with a valid/ready handshake. A format control word, written through a write strobe, selects how each sample is shaped. The block can apply an arithmetic right shift and keep a narrower sample. It can deliver I and Q or only I. In the narrow 8-bit setting it packs two bytes into every host word.

Two widths are supported: full 16-bit with no shift, and 8-bit taken after an arithmetic shift of 8. Any other width/shift pair behaves as the full 16-bit setting. The control word also holds a half-band filter bypass bit, which the block forwards on its own output pin for a filter outside this block. Between the shaping logic and the host port sits a two-word holding queue. A sample whose words do not all fit in the queue is discarded whole, so the word that is on offer never changes under back-pressure.

Top module: `rxfmt_packer`

## Requirements
- R1: After reset, out_valid and hb_bypass are 0, and the format in effect is 16-bit I/Q with no shift (control value 0x300).
- R2: In the 16-bit I/Q setting, each input sample produces two words: the I value first, then the Q value, both unchanged.
- R3: In the 16-bit I-only setting (control bit 9 clear), each sample produces exactly one word equal to I.
- R4: When width bits [8:4] equal 8 and shift bits [3:0] equal 8, with bit 9 set, each sample produces one word. The low byte is I arithmetically shifted right by 8, which is I[15:8]. The high byte is Q shifted the same way.
- R5: In the 8-bit setting with bit 9 clear, a first sample produces no word. The next sample completes a word with the earlier I byte in bits [7:0] and the later one in bits [15:8].
- R6: Any width/shift pair other than 8/8 gives the 16-bit, unshifted behaviour, including pairs such as 8/4 and 12/0.
- R7: Control bits 31:11 have no effect on the data words or on hb_bypass.
- R8: hb_bypass equals bit 10 of the most recent control write, from the cycle after the write. The bit does not alter the data words.
- R9: A control write discards a half-filled packing word. A sample arriving in the same cycle as the write is formatted under the previous settings. If it would only open a new half word, that half is discarded.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_word does not change.
- R11: Words leave in the order they were produced. A sample whose words do not all fit in the two-word queue, after the pop of the current cycle, is discarded entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_data | input | 32 | Control word: [3:0] shift, [8:4] width, [9] deliver Q, [10] filter bypass |
| in_valid | input | 1 | Sample strobe |
| in_i | input | 16 | Signed I sample |
| in_q | input | 16 | Signed Q sample |
| out_valid | output | 1 | Host word available |
| out_ready | input | 1 | Host accepts the word |
| out_word | output | 16 | Host word |
| hb_bypass | output | 1 | Half-band bypass select for the external filter |

## Verification
A control write and a sample strobe can land in the same cycle, so reformatting and packing both act on that edge. The bench provokes this in three ways. In the first, a half word is pending and the write switches to 16-bit, so the sample must complete the pending word under the old byte packing. In the second, no half is pending and the sample would only start a new half, which must vanish. In the third, the old 16-bit I/Q setting meets a write to 8-bit, and the sample must still yield two full words. In each case the collected word list, and the words produced by the samples that follow, are compared with values derived from the requirements.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;

    localparam int WORD_W    = 16;
    localparam int NARROW_W  = 8;
    localparam int CFG_W     = 32;
    localparam int SHIFT_LSB = 0;
    localparam int SHIFT_W   = 4;
    localparam int WIDTH_LSB = 4;
    localparam int WIDTH_W   = 5;
    localparam int QEN_BIT   = 9;
    localparam int BYP_BIT   = 10;

    localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_0300;

    typedef enum logic { FMT_FULL, FMT_HALF } fmt_e;

    typedef struct packed {
        fmt_e               fmt;
        logic               both;
        logic               byp;
        logic [SHIFT_W-1:0] shamt;
    } fmt_cfg_t;

    function automatic fmt_cfg_t decode_fmt(input logic [CFG_W-1:0] r);
        fmt_cfg_t           c;
        logic [WIDTH_W-1:0] wd;
        logic [SHIFT_W-1:0] sh;
        wd     = r[WIDTH_LSB +: WIDTH_W];
        sh     = r[SHIFT_LSB +: SHIFT_W];
        c.both = r[QEN_BIT];
        c.byp  = r[BYP_BIT];
        if (wd == WIDTH_W'(NARROW_W) && sh == SHIFT_W'(WORD_W - NARROW_W)) begin
            c.fmt   = FMT_HALF;
            c.shamt = sh;
        end else begin
            c.fmt   = FMT_FULL;
            c.shamt = '0;
        end
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] shift_full(input logic [WORD_W-1:0] x,
                                                     input logic [SHIFT_W-1:0] sh);
        return WORD_W'($signed(x) >>> sh);
    endfunction

    function automatic logic [NARROW_W-1:0] shift_narrow(input logic [WORD_W-1:0] x,
                                                         input logic [SHIFT_W-1:0] sh);
        logic [WORD_W-1:0] t;
        t = shift_full(x, sh);
        return t[NARROW_W-1:0];
    endfunction

endpackage

// File: rtl/rxfmt_ctl.sv
module rxfmt_ctl
    import rxfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] data,
    output fmt_cfg_t         cfg,
    output logic             bypass
);

    fmt_cfg_t cfg_q;
    logic     unused_hi;

    assign unused_hi = ^data[CFG_W-1:BYP_BIT+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= decode_fmt(CFG_RESET);
        end else if (wr) begin
            cfg_q <= decode_fmt(data);
        end
    end

    assign cfg    = cfg_q;
    assign bypass = cfg_q.byp;

    // R8: bypass pin tracks bit 10 of the last write
    a_r8_bypass_follows: assert property (@(posedge clk) disable iff (rst)
        wr |=> (bypass == $past(data[BYP_BIT])));

endmodule

// File: rtl/rxfmt_shaper.sv
module rxfmt_shaper
    import rxfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fmt_cfg_t          cfg,
    input  logic              flush,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_i,
    input  logic [WORD_W-1:0] smp_q,
    output logic [1:0]        push_n,
    output logic [WORD_W-1:0] push_w0,
    output logic [WORD_W-1:0] push_w1
);

    logic                pend_v;
    logic [NARROW_W-1:0] pend_b;
    logic [NARROW_W-1:0] lo_i, lo_q;
    logic [WORD_W-1:0]   wi, wq;
    logic                pack_mode;

    assign lo_i      = shift_narrow(smp_i, cfg.shamt);
    assign lo_q      = shift_narrow(smp_q, cfg.shamt);
    assign wi        = shift_full(smp_i, cfg.shamt);
    assign wq        = shift_full(smp_q, cfg.shamt);
    assign pack_mode = (cfg.fmt == FMT_HALF) && !cfg.both;

    always_comb begin
        push_n  = 2'd0;
        push_w0 = '0;
        push_w1 = '0;
        if (smp_valid) begin
            if (cfg.fmt == FMT_FULL) begin
                push_w0 = wi;
                push_w1 = wq;
                push_n  = cfg.both ? 2'd2 : 2'd1;
            end else if (cfg.both) begin
                push_w0 = {lo_q, lo_i};
                push_n  = 2'd1;
            end else if (pend_v) begin
                push_w0 = {lo_i, pend_b};
                push_n  = 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend_b <= '0;
        end else begin
            if (smp_valid && pack_mode) begin
                pend_v <= !pend_v;
                pend_b <= lo_i;
            end
            if (flush) begin
                pend_v <= 1'b0;
            end
        end
    end

    // R9: a control write leaves no half word behind
    a_r9_flush_clears_half: assert property (@(posedge clk) disable iff (rst)
        flush |=> !pend_v);

    // R5: the first byte of a pair emits nothing
    a_r5_first_half_silent: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && pack_mode && !pend_v) |-> (push_n == 2'd0));

    // R3: I-only full width gives exactly one word per sample
    a_r3_one_word: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && cfg.fmt == FMT_FULL && !cfg.both) |-> (push_n == 2'd1));

endmodule

// File: rtl/rxfmt_outq.sv
module rxfmt_outq #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   push_n,
    input  logic [W-1:0] push_w0,
    input  logic [W-1:0] push_w1,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_word
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [W-1:0]  shf [DEPTH];
    logic [W-1:0]  nxt [DEPTH];
    logic [CW-1:0] cnt, rem, cnt_n;
    logic [CW:0]   sum;
    logic          pop, room;

    assign out_valid = (cnt != '0);
    assign out_word  = mem[0];
    assign pop       = out_valid && out_ready;
    assign rem       = cnt - CW'(pop);
    assign sum       = {1'b0, rem} + (CW+1)'(push_n);
    assign room      = (sum <= (CW+1)'(DEPTH));
    assign cnt_n     = room ? sum[CW-1:0] : rem;

    always_comb begin
        for (int k = 0; k < DEPTH - 1; k++) begin
            shf[k] = pop ? mem[k+1] : mem[k];
        end
        shf[DEPTH-1] = mem[DEPTH-1];
        for (int k = 0; k < DEPTH; k++) begin
            if (CW'(k) < rem) begin
                nxt[k] = shf[k];
            end else if (room && push_n != 2'd0 && CW'(k) == rem) begin
                nxt[k] = push_w0;
            end else if (room && push_n == 2'd2 && CW'(k) == rem + CW'(1)) begin
                nxt[k] = push_w1;
            end else begin
                nxt[k] = shf[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= '0;
            end
        end else begin
            cnt <= cnt_n;
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= nxt[k];
            end
        end
    end

    // R10: the offered word holds while the host stalls
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    // R11: a full queue with no pop keeps its occupancy whatever arrives
    a_r11_full_no_grow: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(DEPTH) && !out_ready) |=> (cnt == CW'(DEPTH)));

endmodule

// File: rtl/rxfmt_packer.sv
module rxfmt_packer
    import rxfmt_pkg::*;
#(
    parameter int QDEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_i,
    input  logic [WORD_W-1:0] in_q,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic              hb_bypass
);

    fmt_cfg_t          cfg;
    logic [1:0]        push_n;
    logic [WORD_W-1:0] push_w0, push_w1;

    rxfmt_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .data   (cfg_data),
        .cfg    (cfg),
        .bypass (hb_bypass)
    );

    rxfmt_shaper u_shaper (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .flush     (cfg_wr),
        .smp_valid (in_valid),
        .smp_i     (in_i),
        .smp_q     (in_q),
        .push_n    (push_n),
        .push_w0   (push_w0),
        .push_w1   (push_w1)
    );

    rxfmt_outq #(.W(WORD_W), .DEPTH(QDEPTH)) u_outq (
        .clk       (clk),
        .rst       (rst),
        .push_n    (push_n),
        .push_w0   (push_w0),
        .push_w1   (push_w1),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

endmodule

// File: tb/test_rxfmt_packer.sv
module test_rxfmt_packer;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_i = '0, in_q = '0;
    logic        out_valid, out_ready, hb_bypass;
    logic [15:0] out_word;

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [15:0] got [64];
    int          got_n = 0;

    always #(CLK_P/2) clk = ~clk;

    rxfmt_packer i_rxfmt_packer (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .hb_bypass(hb_bypass)
    );

    initial out_ready = 1'b1;

    // collect every accepted word, sampled well after the falling edge
    initial forever begin
        @(negedge clk);
        #(CLK_P/4);
        if (!rst && out_valid && out_ready && got_n < 64) begin
            got[got_n] = out_word;
            got_n++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic send(input logic [15:0] i, input logic [15:0] q);
        @(negedge clk);
        in_valid = 1'b1; in_i = i; in_q = q;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic collide(input logic [31:0] v, input logic [15:0] i, input logic [15:0] q);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_data = v; in_valid = 1'b1; in_i = i; in_q = q;
        @(negedge clk);
        cfg_wr = 1'b0; in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_words(input string req, input int n, input logic [15:0] e0,
                                input logic [15:0] e1, input logic [15:0] e2,
                                input logic [15:0] e3);
        logic [15:0] e [4];
        e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
        idle(4);
        check({req, " word count"}, 32'(got_n), 32'(n));
        for (int k = 0; k < n && k < got_n; k++) begin
            check({req, " word"}, 32'(got[k]), 32'(e[k]));
        end
        got_n = 0;
    endtask

    task automatic t_reset;
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);
        check("R1 hb_bypass after reset", 32'(hb_bypass), 32'd0);
        send(16'h0F0F, 16'hF0F0);
        expect_words("R1 default format", 2, 16'h0F0F, 16'hF0F0, 0, 0);
    endtask

    task automatic t_full_iq;
        write_cfg(32'h300);
        send(16'h1234, 16'hABCD);
        send(16'h8001, 16'h7FFE);
        expect_words("R2 16-bit I/Q", 4, 16'h1234, 16'hABCD, 16'h8001, 16'h7FFE);
    endtask

    task automatic t_full_i;
        write_cfg(32'h100);
        send(16'h5A5A, 16'h1111);
        send(16'hFFFF, 16'h2222);
        expect_words("R3 16-bit I only", 2, 16'h5A5A, 16'hFFFF, 0, 0);
    endtask

    task automatic t_half_iq;
        write_cfg(32'h288);
        send(16'h12F0, 16'hA5FF);
        send(16'h8000, 16'h7F00);
        expect_words("R4 8-bit I/Q", 2, 16'hA512, 16'h7F80, 0, 0);
    endtask

    task automatic t_half_i;
        write_cfg(32'h088);
        send(16'h1100, 16'h9999);
        idle(3);
        check("R5 no word after first byte", 32'(got_n), 32'd0);
        send(16'h2200, 16'h9999);
        send(16'h3300, 16'h9999);
        send(16'hC400, 16'h9999);
        expect_words("R5 8-bit I pairs", 2, 16'h2211, 16'hC433, 0, 0);
    endtask

    task automatic t_fallback;
        write_cfg(32'h284);
        send(16'h1234, 16'h5678);
        expect_words("R6 width 8 shift 4", 2, 16'h1234, 16'h5678, 0, 0);
        write_cfg(32'h2C0);
        send(16'hFEDC, 16'h0123);
        expect_words("R6 width 12 shift 0", 2, 16'hFEDC, 16'h0123, 0, 0);
    endtask

    task automatic t_reserved;
        write_cfg(32'hFFFF_F300);
        check("R7 reserved bits leave bypass", 32'(hb_bypass), 32'd0);
        send(16'h4321, 16'h8765);
        expect_words("R7 reserved bits", 2, 16'h4321, 16'h8765, 0, 0);
    endtask

    task automatic t_bypass;
        write_cfg(32'h700);
        check("R8 bypass set", 32'(hb_bypass), 32'd1);
        send(16'h0101, 16'h0202);
        expect_words("R8 bypass no data effect", 2, 16'h0101, 16'h0202, 0, 0);
        write_cfg(32'h300);
        check("R8 bypass cleared", 32'(hb_bypass), 32'd0);
    endtask

    task automatic t_collide;
        // half pending, rewrite same format: half is lost
        write_cfg(32'h088);
        send(16'hAA00, 16'h0);
        write_cfg(32'h088);
        send(16'h1100, 16'h0);
        send(16'h2200, 16'h0);
        expect_words("R9 write drops half", 1, 16'h2211, 0, 0, 0);
        // no half pending, sample with write opens a half that is discarded
        collide(32'h088, 16'h7700, 16'h0);
        send(16'h3300, 16'h0);
        send(16'h4400, 16'h0);
        expect_words("R9 lone half in write cycle", 1, 16'h4433, 0, 0, 0);
        // half pending, write to 16-bit with a sample: old packing completes
        send(16'h5500, 16'h0);
        collide(32'h300, 16'h6600, 16'h0);
        send(16'hBEEF, 16'hCAFE);
        expect_words("R9 completion under old format", 3, 16'h6655, 16'hBEEF, 16'hCAFE, 0);
        // old 16-bit I/Q meets a write to 8-bit
        collide(32'h088, 16'h1357, 16'h2468);
        expect_words("R9 old format two words", 2, 16'h1357, 16'h2468, 0, 0);
    endtask

    task automatic t_backpressure;
        write_cfg(32'h300);
        @(negedge clk);
        out_ready = 1'b0;
        send(16'hAAAA, 16'hBBBB);
        check("R10 valid held", 32'(out_valid), 32'd1);
        check("R10 word offered", 32'(out_word), 32'hAAAA);
        send(16'hCCCC, 16'hDDDD);
        idle(2);
        check("R10 word stable", 32'(out_word), 32'hAAAA);
        @(negedge clk);
        out_ready = 1'b1;
        expect_words("R11 overflow sample dropped", 2, 16'hAAAA, 16'hBBBB, 0, 0);
        write_cfg(32'h100);
        @(negedge clk);
        out_ready = 1'b0;
        send(16'h0001, 16'h0);
        send(16'h0002, 16'h0);
        send(16'h0003, 16'h0);
        @(negedge clk);
        out_ready = 1'b1;
        expect_words("R11 order and drop I only", 2, 16'h0001, 16'h0002, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_iq();
        t_full_i();
        t_half_iq();
        t_half_i();
        t_fallback();
        t_reserved();
        t_bypass();
        t_collide();
        t_backpressure();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule